// File: doc/BRIEF.md
# Core Voltage Window Monitor

This block watches a digitized sense-voltage code from the supply rail of a processor core. It compares that code against the reference code currently programmed for the rail. From the comparison it produces three things: a power-good indication, an undervoltage flag, and an overvoltage indication in two forms. The first form is a live comparator output with hysteresis, which an external clamp uses for hysteretic shunting. The second is a sticky latch that only power-on reset clears.

All thresholds are fixed ratios of the reference, expressed in hundredths. A ratio test is done by multiplying both sides, for example sense×100 against reference×92, so no divider is needed. The undervoltage test uses a lower threshold while the voltage falls and a higher one while it recovers. The overvoltage comparator also releases a little below its trip point. Every output is registered, so each flag reflects the inputs sampled at the previous rising clock edge.

Top module: `core_vwin_monitor`

## Requirements
- R1: While `porN` is low and right after it rises, `powerGood`=0, `underVolt`=1, `overVoltRaw`=0 and `overVoltLatched`=0.
- R2: When `underVolt` is 0 and sense×100 < ref×90, `underVolt` becomes 1 one clock later.
- R3: When `underVolt` is 1, it stays 1 while sense×100 < ref×92, and it clears one clock after sense×100 ≥ ref×92. A sense value between the two thresholds leaves the flag unchanged.
- R4: When `overVoltRaw` is 0, a non-zero reference with sense×100 > ref×115 sets both `overVoltRaw` and `overVoltLatched` one clock later. Equality does not trip.
- R5: When `overVoltRaw` is 1, it stays 1 while sense×100 ≥ ref×113, and it clears one clock after sense×100 < ref×113.
- R6: Once set, `overVoltLatched` stays 1 for any sense, reference or soft-start input until `porN` goes low.
- R7: `powerGood` is 1 exactly when, in the previous cycle, all of the following held: the next `underVolt` state was 0, the latch was clear and not being set, `softStartDone` was 1, and the reference was non-zero.
- R8: A reference code of 0 forces `powerGood` to 0. It blocks any overvoltage trip, releases `overVoltRaw`, and clears `underVolt`. It does not clear the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| senseCode | input | SENSE_W | Digitized rail voltage |
| refCode | input | REF_W | Programmed reference code; 0 means rail off |
| softStartDone | input | 1 | High once the soft-start ramp has finished |
| powerGood | output | 1 | Rail inside window, ramp done, no latched overvoltage |
| underVolt | output | 1 | Hysteretic undervoltage flag |
| overVoltRaw | output | 1 | Hysteretic overvoltage comparator output |
| overVoltLatched | output | 1 | Sticky overvoltage flag |

## Verification
The assertions check, on every cycle, that the latch never clears outside reset and that the raw overvoltage output never appears without the latch. They also check that power-good is never high together with undervoltage, a latched overvoltage or a missing soft-start, and that a zero reference pulls power-good and the raw comparator low. The bench scenarios are the only place that shows the exact threshold edges. These include the 90/92 dead band holding either state, equality at 115 not tripping, the 113 release point, and that only a reset clears the latch.

// File: rtl/core_vwin_pkg.sv
package core_vwin_pkg;

  // Comparator selection for one ratio threshold.
  typedef enum logic {
    CMP_BELOW = 1'b0,   // sense*den <  ref*num
    CMP_ABOVE = 1'b1    // sense*den >  ref*num
  } cmpMode_e;

  // Threshold indices inside the datapath comparator bank.
  localparam int unsigned IDX_UV_RISE  = 0;
  localparam int unsigned IDX_UV_FALL  = 1;
  localparam int unsigned IDX_OV_TRIP  = 2;
  localparam int unsigned IDX_OV_REL   = 3;
  localparam int unsigned NUM_THRESH   = 4;

  // Strobes from the datapath to the control.
  typedef struct packed {
    logic belowUvRise;     // below recovery threshold
    logic belowUvFall;     // below falling threshold
    logic aboveOvTrip;     // above overvoltage trip
    logic belowOvRelease;  // below overvoltage release
    logic refZero;         // reference is "off"
  } vwinStrobes_t;

endpackage

// File: rtl/vwin_ratio_cmp.sv
module vwin_ratio_cmp
  import core_vwin_pkg::*;
#(
  parameter int unsigned SENSE_W = 10,
  parameter int unsigned REF_W   = 10,
  parameter int unsigned COEF_W  = 8,
  parameter int unsigned NUM     = 100,
  parameter int unsigned DEN     = 100,
  parameter cmpMode_e    MODE    = CMP_BELOW
) (
  input  logic [SENSE_W-1:0] senseCode,
  input  logic [REF_W-1:0]   refCode,
  output logic               hit
);

  localparam int unsigned IN_W   = (SENSE_W > REF_W) ? SENSE_W : REF_W;
  localparam int unsigned PROD_W = IN_W + COEF_W;
  localparam logic [PROD_W-1:0] NUM_P = PROD_W'(NUM);
  localparam logic [PROD_W-1:0] DEN_P = PROD_W'(DEN);

  logic [PROD_W-1:0] senseScaled;
  logic [PROD_W-1:0] refScaled;

  assign senseScaled = PROD_W'(senseCode) * DEN_P;
  assign refScaled   = PROD_W'(refCode) * NUM_P;

  generate
    if (MODE == CMP_ABOVE) begin : g_above
      assign hit = senseScaled > refScaled;
    end else begin : g_below
      assign hit = senseScaled < refScaled;
    end
  endgenerate

endmodule

// File: rtl/vwin_datapath.sv
module vwin_datapath
  import core_vwin_pkg::*;
#(
  parameter int unsigned SENSE_W     = 10,
  parameter int unsigned REF_W       = 10,
  parameter int unsigned COEF_W      = 8,
  parameter int unsigned SCALE       = 100,
  parameter int unsigned UV_RISE_PCT = 92,
  parameter int unsigned UV_FALL_PCT = 90,
  parameter int unsigned OV_TRIP_PCT = 115,
  parameter int unsigned OV_REL_PCT  = 113
) (
  input  logic [SENSE_W-1:0] senseCode,
  input  logic [REF_W-1:0]   refCode,
  output vwinStrobes_t       strobes
);

  localparam int unsigned RATIO [NUM_THRESH] =
    '{UV_RISE_PCT, UV_FALL_PCT, OV_TRIP_PCT, OV_REL_PCT};
  localparam cmpMode_e MODES [NUM_THRESH] =
    '{CMP_BELOW, CMP_BELOW, CMP_ABOVE, CMP_BELOW};

  logic [NUM_THRESH-1:0] hitVec;

  generate
    for (genvar g = 0; g < NUM_THRESH; g++) begin : g_thr
      vwin_ratio_cmp #(
        .SENSE_W (SENSE_W),
        .REF_W   (REF_W),
        .COEF_W  (COEF_W),
        .NUM     (RATIO[g]),
        .DEN     (SCALE),
        .MODE    (MODES[g])
      ) u_cmp (
        .senseCode (senseCode),
        .refCode   (refCode),
        .hit       (hitVec[g])
      );
    end
  endgenerate

  always_comb begin
    strobes.belowUvRise    = hitVec[IDX_UV_RISE];
    strobes.belowUvFall    = hitVec[IDX_UV_FALL];
    strobes.aboveOvTrip    = hitVec[IDX_OV_TRIP];
    strobes.belowOvRelease = hitVec[IDX_OV_REL];
    strobes.refZero        = (refCode == '0);
  end

endmodule

// File: rtl/vwin_ctrl.sv
module vwin_ctrl
  import core_vwin_pkg::*;
(
  input  logic         clk,
  input  logic         porN,
  input  vwinStrobes_t strobes,
  input  logic         softStartDone,
  output logic         powerGood,
  output logic         underVolt,
  output logic         overVoltRaw,
  output logic         overVoltLatched
);

  logic uvNext;
  logic tripNow;
  logic ovNext;
  logic latchNext;
  logic pgNext;

  always_comb begin
    // Undervoltage hysteresis: recovery threshold while low, falling one while good.
    uvNext    = underVolt ? strobes.belowUvRise : strobes.belowUvFall;
    tripNow   = strobes.aboveOvTrip && !strobes.refZero;
    ovNext    = overVoltRaw ? !(strobes.belowOvRelease || strobes.refZero) : tripNow;
    latchNext = overVoltLatched || tripNow;
    pgNext    = !uvNext && !latchNext && softStartDone && !strobes.refZero;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      underVolt       <= 1'b1;
      overVoltRaw     <= 1'b0;
      overVoltLatched <= 1'b0;
      powerGood       <= 1'b0;
    end else begin
      underVolt       <= uvNext;
      overVoltRaw     <= ovNext;
      overVoltLatched <= latchNext;
      powerGood       <= pgNext;
    end
  end

  // R6: latch never drops outside reset
  p_latch_sticky_r6: assert property (@(posedge clk) disable iff (!porN)
    overVoltLatched |=> overVoltLatched);

  // R4: a raw trip is always accompanied by the latch
  p_raw_has_latch_r4: assert property (@(posedge clk) disable iff (!porN)
    overVoltRaw |-> overVoltLatched);

  // R7: power-good excludes undervoltage and latched overvoltage
  p_pg_window_r7: assert property (@(posedge clk) disable iff (!porN)
    powerGood |-> (!underVolt && !overVoltLatched));

  // R7: power-good needs soft-start done in the sampled cycle
  p_pg_softstart_r7: assert property (@(posedge clk) disable iff (!porN)
    powerGood |-> $past(softStartDone));

  // R8: zero reference pulls power-good and the raw comparator low
  p_zero_ref_r8: assert property (@(posedge clk) disable iff (!porN)
    strobes.refZero |=> (!powerGood && !overVoltRaw));

  // R2: falling threshold sets undervoltage
  p_uv_fall_r2: assert property (@(posedge clk) disable iff (!porN)
    (!underVolt && strobes.belowUvFall) |=> underVolt);

endmodule

// File: rtl/core_vwin_monitor.sv
module core_vwin_monitor
  import core_vwin_pkg::*;
#(
  parameter int unsigned SENSE_W     = 10,
  parameter int unsigned REF_W       = 10,
  parameter int unsigned COEF_W      = 8,
  parameter int unsigned SCALE       = 100,
  parameter int unsigned UV_RISE_PCT = 92,
  parameter int unsigned UV_FALL_PCT = 90,
  parameter int unsigned OV_TRIP_PCT = 115,
  parameter int unsigned OV_REL_PCT  = 113
) (
  input  logic               clk,
  input  logic               porN,
  input  logic [SENSE_W-1:0] senseCode,
  input  logic [REF_W-1:0]   refCode,
  input  logic               softStartDone,
  output logic               powerGood,
  output logic               underVolt,
  output logic               overVoltRaw,
  output logic               overVoltLatched
);

  vwinStrobes_t strobes;

  vwin_datapath #(
    .SENSE_W     (SENSE_W),
    .REF_W       (REF_W),
    .COEF_W      (COEF_W),
    .SCALE       (SCALE),
    .UV_RISE_PCT (UV_RISE_PCT),
    .UV_FALL_PCT (UV_FALL_PCT),
    .OV_TRIP_PCT (OV_TRIP_PCT),
    .OV_REL_PCT  (OV_REL_PCT)
  ) u_dp (
    .senseCode (senseCode),
    .refCode   (refCode),
    .strobes   (strobes)
  );

  vwin_ctrl u_ctrl (
    .clk             (clk),
    .porN            (porN),
    .strobes         (strobes),
    .softStartDone   (softStartDone),
    .powerGood       (powerGood),
    .underVolt       (underVolt),
    .overVoltRaw     (overVoltRaw),
    .overVoltLatched (overVoltLatched)
  );

endmodule

// File: tb/core_vwin_monitor_test.sv
module core_vwin_monitor_test;

  localparam int CLK_PERIOD = 10;
  localparam int SW = 10;
  localparam int RW = 10;

  logic          clk = 1'b0;
  logic          porN = 1'b0;
  logic [SW-1:0] senseCode = '0;
  logic [RW-1:0] refCode = '0;
  logic          softStartDone = 1'b0;
  logic          powerGood, underVolt, overVoltRaw, overVoltLatched;

  int vecCount = 0;
  int failCount = 0;

  typedef struct {
    logic  pg;
    logic  uv;
    logic  ovr;
    logic  ovl;
    string tag;
  } expItem_t;

  expItem_t expQ[$];

  // bench model state
  logic mUv = 1'b1, mOv = 1'b0, mLat = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  core_vwin_monitor uut (
    .clk             (clk),
    .porN            (porN),
    .senseCode       (senseCode),
    .refCode         (refCode),
    .softStartDone   (softStartDone),
    .powerGood       (powerGood),
    .underVolt       (underVolt),
    .overVoltRaw     (overVoltRaw),
    .overVoltLatched (overVoltLatched)
  );

  task automatic compare(input expItem_t e);
    vecCount++;
    if ({powerGood, underVolt, overVoltRaw, overVoltLatched} !== {e.pg, e.uv, e.ovr, e.ovl}) begin
      failCount++;
      $display("FAIL %s: pg/uv/ovr/ovl actual=%b%b%b%b expected=%b%b%b%b",
               e.tag, powerGood, underVolt, overVoltRaw, overVoltLatched,
               e.pg, e.uv, e.ovr, e.ovl);
    end
  endtask

  // Driver: drive at negedge, predict from the requirement thresholds.
  task automatic applyVec(input int s, input int r, input logic ss, input string tag);
    expItem_t e;
    bit b92, b90, a115, b113, trip, nUv, nOv, nLat;
    @(negedge clk);
    senseCode     = SW'(s);
    refCode       = RW'(r);
    softStartDone = ss;
    b92  = (s * 100) < (r * 92);
    b90  = (s * 100) < (r * 90);
    a115 = (s * 100) > (r * 115);
    b113 = (s * 100) < (r * 113);
    trip = a115 && (r != 0);
    nUv  = mUv ? b92 : b90;
    nOv  = mOv ? !(b113 || (r == 0)) : trip;
    nLat = mLat || trip;
    e.pg  = !nUv && !nLat && ss && (r != 0);
    e.uv  = nUv;
    e.ovr = nOv;
    e.ovl = nLat;
    e.tag = tag;
    mUv = nUv; mOv = nOv; mLat = nLat;
    expQ.push_back(e);
  endtask

  task automatic doReset();
    expItem_t e;
    @(negedge clk);
    porN = 1'b0;
    @(negedge clk);
    e.pg = 1'b0; e.uv = 1'b1; e.ovr = 1'b0; e.ovl = 1'b0; e.tag = "R1 in reset";
    compare(e);
    @(negedge clk);
    porN = 1'b1;
    mUv = 1'b1; mOv = 1'b0; mLat = 1'b0;
    #1;
    e.tag = "R1 after release";
    compare(e);
  endtask

  // Monitor: pop and compare just after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) compare(expQ.pop_front());
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    doReset();
    applyVec(400, 400, 1'b1, "R3 recover to nominal");
    applyVec(365, 400, 1'b1, "R3 dead band holds good");
    applyVec(360, 400, 1'b1, "R2 equal to 90 does not set");
    applyVec(359, 400, 1'b1, "R2 below 90 sets uv");
    applyVec(367, 400, 1'b1, "R3 below 92 holds uv");
    applyVec(368, 400, 1'b1, "R3 at 92 clears uv");
    applyVec(400, 400, 1'b0, "R7 soft-start low");
    applyVec(400, 400, 1'b1, "R7 soft-start high");
    applyVec(460, 400, 1'b1, "R4 equal to 115 no trip");
    applyVec(461, 400, 1'b1, "R4 above 115 trips");
    applyVec(452, 400, 1'b1, "R5 at 113 holds raw");
    applyVec(451, 400, 1'b1, "R5 below 113 releases");
    applyVec(470, 400, 1'b1, "R5 re-trip hysteretic");
    applyVec(400, 400, 1'b1, "R6 latch holds at nominal");
    applyVec(0, 0, 1'b1, "R8 zero ref with latch");
    applyVec(300, 400, 1'b0, "R6 latch holds under uv");
    applyVec(400, 400, 1'b1, "R6 latch still set");
    @(posedge clk); #2;
    doReset();
    applyVec(900, 0, 1'b1, "R8 zero ref blocks trip");
    applyVec(0, 0, 1'b1, "R8 zero ref uv clear pg low");
    applyVec(200, 200, 1'b1, "R7 good at new ref");
    applyVec(229, 200, 1'b1, "R4 below trip at 200");
    applyVec(231, 200, 1'b1, "R4 trip at 200");
    applyVec(226, 200, 1'b1, "R5 hold at 200");
    applyVec(225, 200, 1'b1, "R5 release at 200");
    @(posedge clk); #2;
    doReset();
    for (int r = 100; r <= 700; r += 150) begin
      for (int s = r - 20; s <= r + 20; s += 10) begin
        applyVec(s, r, 1'b1, "R3 sweep");
      end
      applyVec(r * 88 / 100, r, 1'b1, "R2 sweep drop");
      applyVec(r * 91 / 100, r, 1'b1, "R3 sweep band");
      applyVec(r, r, 1'b1, "R3 sweep back");
    end
    @(posedge clk); #2;
    @(posedge clk); #2;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

endmodule